// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave side of a select-framed serial port. It gives an external host read and write access to a bank of ten 16-bit registers. The host lowers an active-low select, toggles a shift clock and sends a 16-bit header. The slave samples one bit on every falling edge of the shift clock. The header carries, in order: a start bit, a read/write bit, an 8-bit device address, a 4-bit register number and two turnaround bits. Data words of 16 bits follow the header.

While select stays low, each further 16-bit word moves to the next register. The burst ends at the last register. The bidirectional data line is split into a data input, a data output and an output enable, so that the pad can be placed outside the block. The lower nibble of the device address is taken from strap pins when reset is released.

Registers 0 to 7 are control registers and drive the `ctrl_o` bus. Registers 8 and 9 show the `stat_i` inputs and cannot be written. A change on any status bit pulls the active-low interrupt output low. The interrupt clears once the status register holding that bit has been read. The shift clock and select inputs are sampled by the system clock. Each shift-clock level must therefore last at least two system clocks. The data stream has no back-pressure: the host sets the pace by how it toggles the shift clock. This is why the port carries no valid/ready handshake.

Top module: `srp_port`

## Requirements
- R1: After reset the output enable is 0, the data output is 0, the interrupt output is 1 and every control register is 0. Whenever select is high, the output enable is 0 one system clock later.
- R2: The first header bit is the start bit. If it is 1, the frame is abandoned: nothing is written and nothing is driven until select rises.
- R3: Header bits 2 to 9 are the device address, MSB first. Bits 2 to 5 must be 1111 and bits 6 to 9 must equal the strap value. On any mismatch the frame is abandoned.
- R4: Header bit 1 set to 1 selects read. Header bits 10 to 13 give the register number, MSB first. On a read, the output enable rises on the 16th falling edge of the header, with the register's MSB on the output. On each later falling edge the output moves to the next lower bit. The output changes only on a falling edge of the shift clock or on a change of select.
- R5: Header bit 1 set to 0 selects write. Data is sent MSB first. A word is committed only on its 16th data falling edge. A word that is cut short by select rising is discarded.
- R6: While select stays low, each further 16-bit word accesses the register number one higher.
- R7: After the word at register 9 (or at any higher number), the burst halts. The output enable goes to 0 and further clocks have no effect until select rises.
- R8: Registers 8 and 9 read the low and high 16-bit halves of `stat_i`, and ignore writes. Registers 10 to 15 read as 0 and ignore writes.
- R9: The interrupt output goes low within two system clocks of any change on `stat_i`. It returns high once every status register whose bits have changed has been loaded for a read.
- R10: The strap value is captured during reset. Later changes on the strap pins do not affect address matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap value is captured while it is low |
| strap_i | input | 4 | Lower device-address nibble from the strap pins |
| cs_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial shift clock; bits are sampled on its falling edges |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data; 0 when not driving |
| sdo_oe_o | output | 1 | Drive enable for the shared data line |
| stat_i | input | 32 | Status inputs; low half is register 8, high half is register 9 |
| ctrl_o | output | 128 | Control registers 0 to 7; register n is at bits 16n+15 to 16n |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the shift clock and select are synchronous to the system clock, and that each shift-clock level is held for several system clocks. Under this assumption, a falling edge is seen exactly once and the output can change only on the clock that detects that edge. They also assume that `stat_i` is held steady during reset. The bench drives every input on the falling edge of the system clock and holds each shift-clock phase for four system clocks. It keeps the status inputs constant except at deliberate single changes made between frames, so that every interrupt fall has a visible cause.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_HALT = 2'd2
  } srp_state_e;
endpackage

// File: rtl/srp_edge.sv
module srp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end

  assign fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import srp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int SW   = 4,
  parameter int NREG = 10,
  parameter logic [SW-1:0] DEV_HI = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] strap_i,
  input  logic          cs_n_i,
  input  logic          fall_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          ld_o,
  output logic [AW-1:0] ld_addr_o,
  output logic          wr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam int HDRLEN   = 4 + 2*SW + AW;
  localparam int LEN_MAX  = (HDRLEN > DW) ? HDRLEN : DW;
  localparam int CW       = $clog2(LEN_MAX);
  localparam int DEV_BEG  = 2;
  localparam int DEV_END  = 1 + 2*SW;
  localparam int ADDR_BEG = DEV_END + 1;
  localparam int ADDR_END = ADDR_BEG + AW - 1;
  localparam int HDR_END  = HDRLEN - 1;

  srp_state_e        state;
  logic [CW-1:0]     cnt;
  logic              rw_q;
  logic [AW-1:0]     addr_q;
  logic [2*SW-2:0]   dev_sr;
  logic [DW-2:0]     wsr;
  logic [DW-1:0]     osr;
  logic              oe_q;
  logic [SW-1:0]     strap_q;
  logic              last_word;
  logic              hdr_done;
  logic              word_done;

  assign last_word = (addr_q >= AW'(NREG-1));
  assign hdr_done  = fall_i && !cs_n_i && state == ST_HDR  && cnt == CW'(HDR_END);
  assign word_done = fall_i && !cs_n_i && state == ST_DATA && cnt == CW'(DW-1);

  always_comb begin
    ld_o      = rw_q && (hdr_done || (word_done && !last_word));
    ld_addr_o = (state == ST_HDR) ? addr_q : addr_q + 1'b1;
    wr_o      = word_done && !rw_q;
    wr_addr_o = addr_q;
    wr_data_o = {wsr, sdi_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_i;
      state   <= ST_HDR;
      cnt     <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      dev_sr  <= '0;
      wsr     <= '0;
      osr     <= '0;
      oe_q    <= 1'b0;
    end else if (cs_n_i) begin
      state <= ST_HDR;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (fall_i) begin
      case (state)
        ST_HDR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1)) rw_q <= sdi_i;
          if (cnt >= CW'(DEV_BEG) && cnt <= CW'(DEV_END))
            dev_sr <= {dev_sr[2*SW-3:0], sdi_i};
          if (cnt >= CW'(ADDR_BEG) && cnt <= CW'(ADDR_END))
            addr_q <= {addr_q[AW-2:0], sdi_i};
          if (cnt == '0 && sdi_i)
            state <= ST_HALT;
          if (cnt == CW'(DEV_END) && {dev_sr, sdi_i} != {DEV_HI, strap_q})
            state <= ST_HALT;
          if (cnt == CW'(HDR_END)) begin
            state <= ST_DATA;
            cnt   <= '0;
            if (rw_q) begin
              osr  <= rd_data_i;
              oe_q <= 1'b1;
            end
          end
        end
        ST_DATA: begin
          cnt <= cnt + 1'b1;
          wsr <= {wsr[DW-3:0], sdi_i};
          osr <= {osr[DW-2:0], 1'b0};
          if (cnt == CW'(DW-1)) begin
            cnt <= '0;
            if (last_word) begin
              state <= ST_HALT;
              oe_q  <= 1'b0;
            end else begin
              addr_q <= addr_q + 1'b1;
              if (rw_q) osr <= rd_data_i;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdo_oe_o = oe_q;
  assign sdo_o    = oe_q & osr[DW-1];
endmodule

// File: rtl/srp_bank.sv
module srp_bank #(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int NREG  = 10,
  parameter int NCTRL = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_i,
  input  logic [AW-1:0]          ld_addr_i,
  input  logic                   wr_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic [(NREG-NCTRL)*DW-1:0] stat_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [NCTRL*DW-1:0]    ctrl_o,
  output logic                   irq_n_o
);
  localparam int NSTAT = NREG - NCTRL;

  logic [DW-1:0]    ctrl_q [NCTRL];
  logic [DW-1:0]    seen_q [NSTAT];
  logic [NSTAT-1:0] pend;
  logic             irq_n_q;

  for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n)                               ctrl_q[i] <= '0;
      else if (wr_i && wr_addr_i == AW'(i))     ctrl_q[i] <= wr_data_i;
    end
    assign ctrl_o[i*DW +: DW] = ctrl_q[i];
  end

  for (genvar s = 0; s < NSTAT; s++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rst_n)
        seen_q[s] <= stat_i[s*DW +: DW];
      else if (ld_i && ld_addr_i == AW'(NCTRL+s))
        seen_q[s] <= stat_i[s*DW +: DW];
    end
    assign pend[s] = |(stat_i[s*DW +: DW] ^ seen_q[s]);
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCTRL; i++)
      if (ld_addr_i == AW'(i)) rd_data_o = ctrl_q[i];
    for (int s = 0; s < NSTAT; s++)
      if (ld_addr_i == AW'(NCTRL+s)) rd_data_o = stat_i[s*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~|pend;
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/srp_port.sv
module srp_port #(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int SW    = 4,
  parameter int NREG  = 10,
  parameter int NCTRL = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SW-1:0]              strap_i,
  input  logic                       cs_n_i,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  input  logic [(NREG-NCTRL)*DW-1:0] stat_i,
  output logic [NCTRL*DW-1:0]        ctrl_o,
  output logic                       irq_n_o
);
  logic          sclk_fall;
  logic          ld;
  logic [AW-1:0] ld_addr;
  logic          wr;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;

  srp_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .fall_o (sclk_fall)
  );

  srp_frame #(.DW(DW), .AW(AW), .SW(SW), .NREG(NREG)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (strap_i),
    .cs_n_i    (cs_n_i),
    .fall_i    (sclk_fall),
    .sdi_i     (sdi_i),
    .rd_data_i (rd_data),
    .ld_o      (ld),
    .ld_addr_o (ld_addr),
    .wr_o      (wr),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
  );

  srp_bank #(.DW(DW), .AW(AW), .NREG(NREG), .NCTRL(NCTRL)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_i      (ld),
    .ld_addr_i (ld_addr),
    .wr_i      (wr),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .stat_i    (stat_i),
    .rd_data_o (rd_data),
    .ctrl_o    (ctrl_o),
    .irq_n_o   (irq_n_o)
  );
endmodule

// File: rtl/srp_port_chk.sv
module srp_port_chk #(
  parameter int DW    = 16,
  parameter int NREG  = 10,
  parameter int NCTRL = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n_i,
  input logic                       sclk_i,
  input logic [(NREG-NCTRL)*DW-1:0] stat_i,
  input logic [NCTRL*DW-1:0]        ctrl_o,
  input logic                       sdo_o,
  input logic                       sdo_oe_o,
  input logic                       irq_n_o,
  input logic                       sclk_fall
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> !sdo_oe_o);

  assert_sdo_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(sclk_i) && $stable(cs_n_i)) |=> $stable(sdo_o));

  assert_oe_rise_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> ($past(sclk_fall) && !$past(cs_n_i)));

  assert_ctrl_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(ctrl_o));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> ($past(stat_i) != $past(stat_i, 2)));
endmodule

bind srp_port srp_port_chk #(.DW(DW), .NREG(NREG), .NCTRL(NCTRL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n_i    (cs_n_i),
  .sclk_i    (sclk_i),
  .stat_i    (stat_i),
  .ctrl_o    (ctrl_o),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o),
  .irq_n_o   (irq_n_o),
  .sclk_fall (sclk_fall)
);

// File: tb/srp_port_test.sv
module srp_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam logic [3:0] STRAP = 4'h6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   strap_i;
  logic         cs_n_i, sclk_i, sdi_i;
  logic         sdo_o, sdo_oe_o, irq_n_o;
  logic [31:0]  stat_i;
  logic [127:0] ctrl_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] wbuf [16];
  logic [15:0] rbuf [16];
  logic [15:0] obuf [16];
  logic [15:0] mctrl [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  srp_port uut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cs_n_i(cs_n_i),
    .sclk_i(sclk_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .stat_i(stat_i), .ctrl_o(ctrl_o), .irq_n_o(irq_n_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'(((a + 1) * 16'h3A5B) ^ (k * 16'h0F0F) ^ 16'h8001);
  endfunction

  function automatic logic [127:0] mflat();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = mctrl[i];
    return v;
  endfunction

  function automatic logic [15:0] exp_rd(input int a);
    if (a < 8)  return mctrl[a];
    if (a == 8) return stat_i[15:0];
    if (a == 9) return stat_i[31:16];
    return 16'h0000;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slot(input logic b);
    sdi_i = b; sclk_i = 1'b1; wait_n(HALF);
    sclk_i = 1'b0; wait_n(HALF);
  endtask

  // cut < 0: no cut; otherwise select rises after cut data bits
  task automatic frame(input logic st, input logic rw, input logic [7:0] dev,
                       input logic [3:0] a, input int nwords, input int cut);
    logic [15:0] hdr;
    int nbits;
    hdr = {st, rw, dev, a, 2'b00};
    nbits = 0;
    for (int w = 0; w < 16; w++) begin rbuf[w] = '0; obuf[w] = '0; end
    cs_n_i = 1'b0; wait_n(HALF);
    for (int j = 15; j >= 0; j--) slot(hdr[j]);
    for (int w = 0; w < nwords; w++) begin
      for (int j = 15; j >= 0; j--) begin
        if (cut >= 0 && nbits == cut) break;
        sdi_i = wbuf[w][j]; sclk_i = 1'b1; wait_n(HALF);
        rbuf[w][j] = sdo_o; obuf[w][j] = sdo_oe_o;
        sclk_i = 1'b0; wait_n(HALF);
        nbits++;
      end
    end
    cs_n_i = 1'b1; sdi_i = 1'b0; wait_n(2*HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] dev;
    dev = {4'hF, STRAP};
    rst_n = 1'b0; strap_i = STRAP; cs_n_i = 1'b1; sclk_i = 1'b0; sdi_i = 1'b0;
    stat_i = 32'h1111_2222;
    for (int i = 0; i < 8; i++) mctrl[i] = '0;
    wait_n(5); rst_n = 1'b1; wait_n(3);

    // R1: reset state
    chk("R1 oe after reset", sdo_oe_o, 0);
    chk("R1 sdo after reset", sdo_o, 0);
    chk("R1 irq after reset", irq_n_o, 1);
    chk("R1 ctrl after reset", ctrl_o, 0);

    // R10: strap pins move after reset; matching keeps the captured value
    strap_i = 4'h9;

    // R5, R8: single-word write sweep over all 16 register numbers
    for (int a = 0; a < 16; a++) begin
      wbuf[0] = pat(a, 0);
      frame(1'b0, 1'b0, dev, 4'(a), 1, -1);
      if (a < 8) mctrl[a] = pat(a, 0);
      chk($sformatf("R5 R8 write addr %0d", a), ctrl_o, mflat());
    end

    // R4, R8: single-word read sweep
    for (int a = 0; a < 16; a++) begin
      frame(1'b0, 1'b1, dev, 4'(a), 1, -1);
      chk($sformatf("R4 R8 read addr %0d", a), rbuf[0], exp_rd(a));
      chk($sformatf("R4 oe addr %0d", a), obuf[0], 16'hFFFF);
      chk("R1 oe idle", sdo_oe_o, 0);
    end

    // R6, R7: burst write from 0, twelve words
    for (int w = 0; w < 12; w++) wbuf[w] = pat(w, 1);
    frame(1'b0, 1'b0, dev, 4'd0, 12, -1);
    for (int i = 0; i < 8; i++) mctrl[i] = pat(i, 1);
    chk("R6 burst write", ctrl_o, mflat());

    // R6, R7: burst read from 0, twelve words
    frame(1'b0, 1'b1, dev, 4'd0, 12, -1);
    for (int w = 0; w < 10; w++) begin
      chk($sformatf("R6 burst read word %0d", w), rbuf[w], exp_rd(w));
      chk($sformatf("R6 burst oe word %0d", w), obuf[w], 16'hFFFF);
    end
    chk("R7 halt word 10", obuf[10], 0);
    chk("R7 halt word 11", obuf[11], 0);

    // R7: burst from 7
    frame(1'b0, 1'b1, dev, 4'd7, 5, -1);
    for (int w = 0; w < 3; w++)
      chk($sformatf("R7 read from 7 word %0d", w), rbuf[w], exp_rd(7 + w));
    chk("R7 from 7 halted", {obuf[3], obuf[4]}, 0);

    // R7, R8: burst from 12 halts after one zero word
    frame(1'b0, 1'b1, dev, 4'd12, 2, -1);
    chk("R8 addr 12 reads zero", rbuf[0], 0);
    chk("R7 addr 12 halted", obuf[1], 0);

    // R2: start bit 1 abandons
    wbuf[0] = 16'hDEAD;
    frame(1'b1, 1'b0, dev, 4'd3, 1, -1);
    chk("R2 start=1 write ignored", ctrl_o, mflat());
    frame(1'b1, 1'b1, dev, 4'd3, 1, -1);
    chk("R2 start=1 no drive", obuf[0], 0);

    // R3, R10: lower nibble sweep (9 is the current strap pin value)
    for (int n = 0; n < 16; n++) begin
      if (n == int'(STRAP)) continue;
      wbuf[0] = 16'hBEEF;
      frame(1'b0, 1'b0, {4'hF, 4'(n)}, 4'd2, 1, -1);
      chk($sformatf("R3 R10 dev low %0d write ignored", n), ctrl_o, mflat());
      frame(1'b0, 1'b1, {4'hF, 4'(n)}, 4'd2, 1, -1);
      chk($sformatf("R3 R10 dev low %0d no drive", n), obuf[0], 0);
    end
    frame(1'b0, 1'b0, {4'hE, STRAP}, 4'd2, 1, -1);
    chk("R3 upper nibble write ignored", ctrl_o, mflat());
    frame(1'b0, 1'b1, {4'h7, STRAP}, 4'd2, 1, -1);
    chk("R3 upper nibble no drive", obuf[0], 0);
    frame(1'b0, 1'b1, dev, 4'd0, 1, -1);
    chk("R10 captured strap still matches", rbuf[0], mctrl[0]);

    // R5: cut words discarded
    wbuf[0] = 16'h0F0F;
    frame(1'b0, 1'b0, dev, 4'd4, 1, 10);
    chk("R5 cut single word", ctrl_o, mflat());
    wbuf[0] = 16'h1357; wbuf[1] = 16'h2468;
    frame(1'b0, 1'b0, dev, 4'd5, 2, 23);
    mctrl[5] = 16'h1357;
    chk("R5 cut second word", ctrl_o, mflat());

    // R9: interrupt
    chk("R9 irq idle", irq_n_o, 1);
    stat_i[0] = ~stat_i[0]; wait_n(3);
    chk("R9 irq on change", irq_n_o, 0);
    frame(1'b0, 1'b1, dev, 4'd9, 1, -1);
    chk("R9 other reg read keeps irq", irq_n_o, 0);
    frame(1'b0, 1'b1, dev, 4'd8, 1, -1);
    chk("R9 read value", rbuf[0], stat_i[15:0]);
    chk("R9 irq cleared", irq_n_o, 1);
    stat_i[31:24] = 8'hC3; wait_n(3);
    chk("R9 irq on high reg change", irq_n_o, 0);
    frame(1'b0, 1'b1, dev, 4'd8, 2, -1);
    chk("R9 burst read value", rbuf[1], stat_i[31:16]);
    chk("R9 irq cleared by burst", irq_n_o, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule